// File: doc/BRIEF.md
# Translation Lookaside Buffer with Permission Checking

This block keeps the eight most useful virtual-to-physical page translations close to the CPU. Each cycle the CPU may present a 32-bit virtual address with an access kind (load, store or instruction fetch). When the virtual page number matches a resident entry, the physical address comes back in the same cycle: the cached physical page number with the 12-bit page offset appended unchanged. The entry's permission bits are checked against the access kind, and a disallowed access completes with a fault.

When no entry matches, the block asks an external page table walker for the translation and stalls further lookups until it answers. A good answer is installed and the CPU retries, this time hitting. A faulting answer goes straight back to the CPU and is not cached. A store to a writable page whose cached dirty bit is clear is sent to the walker like a miss, so the walker can mark the page dirty and the refreshed entry replaces the stale one. A flush input, used on a process switch, empties the whole buffer in one cycle.

Top module: `xlat_lookaside`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, `walk_req` is 0 and `rsp_done` is 0. The first lookup of any page therefore goes to the walker.
- R2: A lookup of a resident page whose permissions allow the access raises `rsp_done` in the same cycle, with `rsp_fault`=0 and `rsp_paddr` = {cached physical page number, `req_vaddr[11:0]`}.
- R3: A lookup that misses raises `walk_req` from the next cycle on. It carries `walk_vpn` = `req_vaddr[31:12]` and `walk_kind` = the request's kind, and all three hold steady until `walk_rsp_valid`. `req_ready` stays 0 the whole time.
- R4: Access kinds are encoded as load=0, store=1 and fetch=2. Loads need the R bit, stores need W and fetches need X. A resident hit that lacks the needed bit completes in the same cycle with `rsp_done`=1 and `rsp_fault`=1.
- R5: A store that hits an entry with W=1 and D=0 does not complete. It is handled like a miss and goes to the walker.
- R6: A walker answer with `walk_rsp_fault`=1 raises `rsp_done`=1 and `rsp_fault`=1 in that same cycle, and installs nothing. A retry of the same page walks again.
- R7: A good walker answer installs {`walk_vpn`, `walk_rsp_ppn`, `walk_rsp_perm`}. If an entry already holds that page it is overwritten; otherwise the lowest-numbered invalid entry is used. The `walk_rsp_perm` bits are 0=V, 1=R, 2=W, 3=X, 4=D.
- R8: When all entries are valid, a fill evicts the least recently used entry. Both hits and fills count as uses.
- R9: `flush` invalidates every entry at the next edge and holds `req_ready` at 0 while it is high. A walker answer that arrives in the same cycle as `flush` is discarded.
- R10: The buffer holds eight entries, and no page is ever cached in more than one entry at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_done | output | 1 | Access completed this cycle |
| rsp_fault | output | 1 | Completed access is a fault |
| rsp_paddr | output | 32 | Translated physical address |
| walk_req | output | 1 | Walk request pending |
| walk_vpn | output | 20 | Page number to walk |
| walk_kind | output | 2 | Access kind that caused the walk |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_fault | input | 1 | Walker found no valid mapping |
| walk_rsp_ppn | input | 20 | Physical page number from the walker |
| walk_rsp_perm | input | 5 | Permission and dirty bits from the walker |

## Verification
The bench aims at the cases a buffer like this most easily gets wrong. A store to a clean writable page must go to the walker; a design that skipped this would complete the store at once and leave the page never marked dirty. A faulting walk must not be cached; a design that cached it would hit on the retry. A fill that coincides with a flush must be dropped; a design that kept it would let a stale mapping survive a process switch. The bench also checks that a refill of a page already present replaces the old entry instead of duplicating it. Eviction order is probed by touching the oldest entry before an overflow fill, and then confirming which page was lost, which exposes any policy other than least-recently-used.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = ADDR_W - OFF_W;
    localparam int PPN_W  = 20;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    // bit 0 valid, 1 read, 2 write, 3 execute, 4 dirty
    typedef struct packed {
        logic d;
        logic x;
        logic w;
        logic r;
        logic v;
    } perm_t;

    typedef struct packed {
        vpn_t  vpn;
        ppn_t  ppn;
        perm_t perm;
    } entry_t;

    function automatic logic access_allowed(perm_t p, acc_e k);
        case (k)
            ACC_LOAD:  return p.r;
            ACC_STORE: return p.w;
            ACC_FETCH: return p.x;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic clean_store(perm_t p, acc_e k);
        return (k == ACC_STORE) && p.w && !p.d;
    endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  vpn_t            look_vpn,
    input  logic            fill_en,
    input  logic [IW-1:0]   fill_idx,
    input  entry_t          fill_entry,
    output logic [N_ENT-1:0] match_vec,
    output logic [IW-1:0]   match_idx,
    output ppn_t            match_ppn,
    output perm_t           match_perm,
    output logic [N_ENT-1:0] valid_vec
);

    entry_t          ent_q [N_ENT];
    logic [N_ENT-1:0] valid_q;

    assign valid_vec = valid_q;

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_slot
            assign match_vec[g] = valid_q[g] && (ent_q[g].vpn == look_vpn);

            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q[g] <= 1'b0;
                    ent_q[g]   <= '0;
                end else if (flush) begin
                    valid_q[g] <= 1'b0;
                end else if (fill_en && (fill_idx == IW'(g))) begin
                    valid_q[g] <= 1'b1;
                    ent_q[g]   <= fill_entry;
                end
            end
        end
    endgenerate

    always_comb begin
        match_idx  = '0;
        match_ppn  = '0;
        match_perm = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match_vec[i]) begin
                match_idx  = IW'(i);
                match_ppn  = match_ppn | ent_q[i].ppn;
                match_perm = match_perm | ent_q[i].perm;
            end
        end
    end

    p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    p_unique_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IW-1:0]    touch_idx,
    input  logic [N_ENT-1:0] valid_vec,
    output logic [IW-1:0]    victim_idx
);

    // age 0 = most recent, N_ENT-1 = least recent; ages form a permutation
    logic [IW-1:0] age_q [N_ENT];

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_age
            always_ff @(posedge clk) begin
                if (rst) begin
                    age_q[g] <= IW'(g);
                end else if (touch_en) begin
                    if (touch_idx == IW'(g)) begin
                        age_q[g] <= '0;
                    end else if (age_q[g] < age_q[touch_idx]) begin
                        age_q[g] <= age_q[g] + 1'b1;
                    end
                end
            end
        end
    endgenerate

    logic found_free;

    always_comb begin
        victim_idx = '0;
        found_free = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!valid_vec[i] && !found_free) begin
                victim_idx = IW'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (age_q[i] == IW'(N_ENT - 1)) victim_idx = IW'(i);
            end
        end
    end

    p_touch_newest_r8: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (age_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/xlat_lookaside.sv
module xlat_lookaside
    import xlat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    output logic        rsp_done,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        walk_req,
    output logic [19:0] walk_vpn,
    output logic [1:0]  walk_kind,
    input  logic        walk_rsp_valid,
    input  logic        walk_rsp_fault,
    input  logic [19:0] walk_rsp_ppn,
    input  logic [4:0]  walk_rsp_perm
);

    typedef enum logic {ST_IDLE, ST_WALK} st_e;

    st_e  state_q;
    vpn_t pend_vpn_q;
    acc_e pend_kind_q;

    vpn_t             look_vpn;
    logic [N_ENT-1:0] match_vec;
    logic [N_ENT-1:0] valid_vec;
    logic [IW-1:0]    match_idx;
    logic [IW-1:0]    victim_idx;
    ppn_t             match_ppn;
    perm_t            match_perm;
    acc_e             kind;
    logic             hit, accept, dirty_miss, perm_bad, start_walk;
    logic             walk_answer, walk_fail, fill_en;
    logic             touch_en;
    logic [IW-1:0]    touch_idx, fill_idx;
    entry_t           fill_entry;

    assign kind     = acc_e'(req_kind);
    assign look_vpn = (state_q == ST_WALK) ? pend_vpn_q : req_vaddr[ADDR_W-1:OFF_W];
    assign hit      = |match_vec;

    assign req_ready  = (state_q == ST_IDLE) && !flush;
    assign accept     = req_valid && req_ready;
    assign perm_bad   = !access_allowed(match_perm, kind);
    assign dirty_miss = clean_store(match_perm, kind);
    assign start_walk = accept && (!hit || dirty_miss);

    assign walk_answer = (state_q == ST_WALK) && walk_rsp_valid;
    assign walk_fail   = walk_answer && walk_rsp_fault;
    assign fill_en     = walk_answer && !walk_rsp_fault && !flush;

    // refill of a page already cached (clean store) reuses its slot
    assign fill_idx   = hit ? match_idx : victim_idx;
    assign fill_entry = '{vpn: pend_vpn_q, ppn: walk_rsp_ppn, perm: perm_t'(walk_rsp_perm)};

    assign touch_en  = fill_en || (accept && hit);
    assign touch_idx = fill_en ? fill_idx : match_idx;

    assign rsp_done  = (accept && hit && !dirty_miss) || walk_fail;
    assign rsp_fault = (accept && hit && perm_bad) || walk_fail;
    assign rsp_paddr = {match_ppn, req_vaddr[OFF_W-1:0]};

    assign walk_req  = (state_q == ST_WALK);
    assign walk_vpn  = pend_vpn_q;
    assign walk_kind = pend_kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_vpn_q  <= '0;
            pend_kind_q <= ACC_LOAD;
        end else begin
            case (state_q)
                ST_IDLE: if (start_walk) begin
                    state_q     <= ST_WALK;
                    pend_vpn_q  <= req_vaddr[ADDR_W-1:OFF_W];
                    pend_kind_q <= kind;
                end
                ST_WALK: if (walk_rsp_valid) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    xlat_cam #(.N_ENT(N_ENT)) i_cam (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .look_vpn   (look_vpn),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_entry (fill_entry),
        .match_vec  (match_vec),
        .match_idx  (match_idx),
        .match_ppn  (match_ppn),
        .match_perm (match_perm),
        .valid_vec  (valid_vec)
    );

    xlat_lru #(.N_ENT(N_ENT)) i_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (valid_vec),
        .victim_idx (victim_idx)
    );

    p_start_walk_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !rsp_done) |=>
            (walk_req && walk_vpn == $past(req_vaddr[31:12])));

    p_walk_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_rsp_valid) |=>
            (walk_req && $stable(walk_vpn) && $stable(walk_kind)));

    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !req_ready);

    p_fault_not_cached_r6: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_rsp_valid && walk_rsp_fault && !flush) |=>
            (valid_vec == $past(valid_vec)));

    p_flush_drops_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_rsp_valid && flush) |=> (valid_vec == '0));

endmodule

// File: tb/test_xlat_lookaside.sv
`timescale 1ns/1ps
module test_xlat_lookaside;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_done, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic [1:0]  walk_kind;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;
    logic [4:0]  walk_rsp_perm = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic dirty [64];

    always #2 clk = ~clk;

    xlat_lookaside i_xlat_lookaside (.*);

    // bench page table over pages 0..63
    function automatic logic [19:0] pt_ppn(int v);
        return 20'h80000 | 20'((v * 97) + 'h321);
    endfunction
    function automatic logic pt_r(int v);     return (v % 5) != 3; endfunction
    function automatic logic pt_w(int v);     return v[0];         endfunction
    function automatic logic pt_x(int v);     return v[1];         endfunction
    function automatic logic pt_fault(int v); return (v % 11) == 10; endfunction
    function automatic logic allowed(int v, logic [1:0] k);
        case (k)
            2'd0:    return pt_r(v);
            2'd1:    return pt_w(v);
            default: return pt_x(v);
        endcase
    endfunction

    task automatic check(input logic ok, input string rq, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    // one CPU access, with the bench acting as walker; exp_walk -1 = no check
    task automatic access(input int v, input logic [11:0] off, input logic [1:0] k,
                          input int exp_walk, input string rq);
        int   walks = 0;
        logic fin   = 1'b0;
        for (int t = 0; t < 3 && !fin; t++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_vaddr = {v[19:0], off};
            req_kind  = k;
            #1;
            if (rsp_done) begin
                check(rsp_fault == !allowed(v, k), rq, "hit fault",
                      rsp_fault, !allowed(v, k));
                if (allowed(v, k))
                    check(rsp_paddr == {pt_ppn(v), off}, rq, "hit paddr",
                          rsp_paddr, {pt_ppn(v), off});
                fin = 1'b1;
                @(negedge clk);
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
                req_valid = 1'b0;
                #1;
                walks++;
                check(walk_req && walk_vpn == v[19:0] && walk_kind == k, "R3",
                      "walk request", {walk_req, walk_vpn}, {1'b1, v[19:0]});
                check(!req_ready, "R3", "ready during walk", req_ready, 0);
                if (k == 2'd1 && pt_w(v)) dirty[v] = 1'b1;
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = pt_fault(v);
                walk_rsp_ppn   = pt_ppn(v);
                walk_rsp_perm  = {dirty[v], pt_x(v), pt_w(v), pt_r(v), 1'b1};
                #0.5;
                if (pt_fault(v)) begin
                    check(rsp_done && rsp_fault, "R6", "fault forwarded",
                          {rsp_done, rsp_fault}, 2'b11);
                    fin = 1'b1;
                end
                @(negedge clk);
                walk_rsp_valid = 1'b0;
                walk_rsp_fault = 1'b0;
            end
        end
        check(fin, rq, "access completed", fin, 1);
        if (exp_walk >= 0)
            check(walks == exp_walk, rq, "walk count", walks, exp_walk);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        #1;
        check(!req_ready, "R9", "ready during flush", req_ready, 0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dirty[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(walk_req == 1'b0, "R1", "no walk after reset", walk_req, 0);
        check(rsp_done == 1'b0, "R1", "no response after reset", rsp_done, 0);
        access(2, 12'h000, 2'd0, 1, "R1");

        // R2, R7, R10: sweep pages 0..7 with every kind, then all resident
        for (int v = 0; v < 8; v++)
            for (int k = 0; k < 3; k++)
                access(v, 12'(v * 291 + k * 17), 2'(k), -1, "R2");
        for (int v = 0; v < 8; v++)
            for (int k = 0; k < 3; k++)
                access(v, 12'hFFF - 12'(v), 2'(k), 0, "R10");

        // R9: flush clears everything
        do_flush();
        access(3, 12'h5A5, 2'd0, 1, "R9");

        // R4, R5: permissions and dirty handling (page 9: r, w, no x, clean)
        do_flush();
        access(9, 12'h010, 2'd0, 1, "R4");
        access(9, 12'h010, 2'd0, 0, "R4");
        access(9, 12'h020, 2'd1, 1, "R5");
        access(9, 12'h030, 2'd1, 0, "R7");
        access(9, 12'h040, 2'd2, 0, "R4");
        access(12, 12'h050, 2'd1, 1, "R4");
        access(12, 12'h060, 2'd1, 0, "R4");
        access(14, 12'h070, 2'd2, 1, "R4");
        access(13, 12'h080, 2'd0, 1, "R4");

        // R6: faulting page is never cached
        access(21, 12'h100, 2'd0, 1, "R6");
        access(21, 12'h100, 2'd0, 1, "R6");

        // R9: fill coinciding with flush is discarded
        do_flush();
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {20'd17, 12'h123};
        req_kind  = 2'd0;
        @(negedge clk);
        req_valid      = 1'b0;
        walk_rsp_valid = 1'b1;
        walk_rsp_ppn   = pt_ppn(17);
        walk_rsp_perm  = {dirty[17], pt_x(17), pt_w(17), pt_r(17), 1'b1};
        flush          = 1'b1;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        flush          = 1'b0;
        access(17, 12'h123, 2'd0, 1, "R9");

        // R8: least recently used eviction
        do_flush();
        for (int v = 44; v < 52; v++) access(v, 12'h008, 2'd0, 1, "R8");
        access(44, 12'h00C, 2'd0, 0, "R8");
        access(52, 12'h00C, 2'd0, 1, "R8");
        access(44, 12'h00C, 2'd0, 0, "R8");
        for (int v = 46; v < 52; v++) access(v, 12'h004, 2'd0, 0, "R8");
        access(45, 12'h004, 2'd0, 1, "R8");
        access(52, 12'h004, 2'd0, 1, "R8");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule